// File: doc/BRIEF.md
# Data Bus Inversion Codec

This block limits how many lines of a 64-bit active-low data bus are pulled electrically low in any one transfer. The bus is split into four 16-bit lanes. Each lane has its own active-low inversion flag, and each lane makes its own choice to invert.

On the transmit side, a logical word arrives with a valid strobe. The encoder counts the ones in each lane. A logical one means an electrical low on an active-low bus. When a lane would pull nine or more of its sixteen lines low, the encoder sends that lane's bits uninverted and asserts the lane's flag. It then registers the 64 lines and 4 flags for the next clock.

On the receive side, a combinational decoder takes the lines and flags and rebuilds the logical word. One word can be encoded every clock. Idle cycles leave the whole bus and all flags released high.

Top module: `dbi_codec`

## Requirements
- R1: A lane that is not inverted drives each line as the complement of its logical bit (logical 1 = electrical 0), with its flag high.
- R2: Lane i carries logical bits 16i+15 down to 16i on enc_bus_n at the same positions, and its flag is enc_flag_n[i].
- R3: A lane whose logical word holds 9 or more ones is sent inverted: each line equals its logical bit, and the lane's flag is driven 0.
- R4: A lane holding exactly 8 ones is not inverted, and its flag stays 1.
- R5: The choice for one lane does not depend on the contents of any other lane.
- R6: When enc_valid_in is high at a rising edge, enc_bus_n, enc_flag_n and enc_valid_out=1 reflect that word after that edge. A new word is accepted on every edge.
- R7: When enc_valid_in is low at a rising edge, every enc_bus_n line and flag is 1 after that edge, and enc_valid_out is 0.
- R8: While enc_valid_out is high, no lane has more than 8 of its 16 lines at 0.
- R9: The decoder outputs dec_bus_n for a lane whose dec_flag_n bit is 0, and the complement of dec_bus_n for a lane whose flag bit is 1. It responds combinationally.
- R10: Feeding the encoder outputs into the decoder gives back the word presented to the encoder.
- R11: A synchronous active-high rst sets all encoder lines and flags to 1 and enc_valid_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_in | input | 1 | Word to encode is present |
| enc_data_in | input | 64 | Logical word to encode |
| enc_valid_out | output | 1 | Encoded word on the bus |
| enc_bus_n | output | 64 | Electrical data lines, active low |
| enc_flag_n | output | 4 | Per-lane inversion flags, active low |
| dec_bus_n | input | 64 | Received electrical data lines |
| dec_flag_n | input | 4 | Received inversion flags |
| dec_data_out | output | 64 | Restored logical word |

## Verification
The hardest case to reach from the ports is a lane that sits exactly at the inversion threshold while its neighbours in the same word sit on the other side of it. Random words seldom land on a count of exactly 8 or 9. The directed stimulus therefore builds words lane by lane from chosen ones-counts: 8, 9, 0 and 16 mixed in one transfer. The words then go back to back with no idle cycle, so any leakage between lanes or between cycles shows up.

// File: rtl/dbi_codec.sv
module dbi_codec #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid_in,
  input  logic [DATA_W-1:0] enc_data_in,
  output logic              enc_valid_out,
  output logic [DATA_W-1:0] enc_bus_n,
  output logic [DATA_W/LANE_W-1:0] enc_flag_n,
  input  logic [DATA_W-1:0] dec_bus_n,
  input  logic [DATA_W/LANE_W-1:0] dec_flag_n,
  output logic [DATA_W-1:0] dec_data_out
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int CW = $clog2(LANE_W + 1);
  localparam logic [CW-1:0] INV_MIN = CW'(LANE_W / 2 + 1);

  function automatic logic [CW-1:0] ones(input logic [LANE_W-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int k = 0; k < LANE_W; k++) n = n + CW'(v[k]);
    return n;
  endfunction

  logic [LANES-1:0]  inv;
  logic [DATA_W-1:0] bus_nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [LANE_W-1:0] d = enc_data_in[i*LANE_W +: LANE_W];
    assign inv[i] = ones(d) >= INV_MIN;
    assign bus_nxt[i*LANE_W +: LANE_W] = inv[i] ? d : ~d;
    assign dec_data_out[i*LANE_W +: LANE_W] = dec_flag_n[i] ?
        ~dec_bus_n[i*LANE_W +: LANE_W] : dec_bus_n[i*LANE_W +: LANE_W];

    assert_lane_lows_R8: assert property (@(posedge clk) disable iff (rst)
      enc_valid_out |-> $countones(~enc_bus_n[i*LANE_W +: LANE_W]) <= LANE_W/2);

    assert_flagged_lane_R3: assert property (@(posedge clk) disable iff (rst)
      !rst && enc_valid_in && ones(enc_data_in[i*LANE_W +: LANE_W]) >= INV_MIN
      |=> !enc_flag_n[i] && enc_bus_n[i*LANE_W +: LANE_W] == $past(enc_data_in[i*LANE_W +: LANE_W]));

    assert_tie_plain_R4: assert property (@(posedge clk) disable iff (rst)
      !rst && enc_valid_in && ones(enc_data_in[i*LANE_W +: LANE_W]) == CW'(LANE_W/2)
      |=> enc_flag_n[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || !enc_valid_in) begin
      enc_bus_n  <= '1;
      enc_flag_n <= '1;
    end else begin
      enc_bus_n  <= bus_nxt;
      enc_flag_n <= ~inv;
    end
    enc_valid_out <= !rst && enc_valid_in;
  end

  function automatic logic [DATA_W-1:0] restore(input logic [DATA_W-1:0] b,
                                                input logic [LANES-1:0] f);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++)
      r[k*LANE_W +: LANE_W] = f[k] ? ~b[k*LANE_W +: LANE_W] : b[k*LANE_W +: LANE_W];
    return r;
  endfunction

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    !rst && enc_valid_in |=> enc_valid_out);

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
    !enc_valid_out |-> (&enc_bus_n) && (&enc_flag_n));

  assert_roundtrip_R10: assert property (@(posedge clk) disable iff (rst)
    enc_valid_out |-> restore(enc_bus_n, enc_flag_n) == $past(enc_data_in));
endmodule

// File: tb/sim_dbi_codec.sv
`timescale 1ns/1ps
module sim_dbi_codec;
  logic        clk = 0;
  logic        rst;
  logic        enc_valid_in;
  logic [63:0] enc_data_in;
  logic        enc_valid_out;
  logic [63:0] enc_bus_n;
  logic [3:0]  enc_flag_n;
  logic [63:0] dec_bus_n;
  logic [3:0]  dec_flag_n;
  logic [63:0] dec_data_out;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dbi_codec u0 (.clk, .rst, .enc_valid_in, .enc_data_in, .enc_valid_out,
                .enc_bus_n, .enc_flag_n, .dec_bus_n, .dec_flag_n, .dec_data_out);

  function automatic logic [15:0] lane_with(int n, int rot);
    logic [15:0] v = '0;
    for (int k = 0; k < n; k++) v[(k + rot) % 16] = 1'b1;
    return v;
  endfunction

  function automatic void expect_enc(input logic [63:0] d, output logic [63:0] b,
                                     output logic [3:0] f);
    for (int l = 0; l < 4; l++) begin
      int c = 0;
      for (int k = 0; k < 16; k++) c += d[16*l+k];
      f[l] = !(c > 8);
      b[16*l +: 16] = (c > 8) ? d[16*l +: 16] : ~d[16*l +: 16];
    end
  endfunction

  task automatic chk(string req, logic [67:0] act, logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic encode_check(string req, logic [63:0] d);
    logic [63:0] b; logic [3:0] f;
    @(negedge clk); enc_valid_in = 1; enc_data_in = d;
    @(negedge clk);
    expect_enc(d, b, f);
    chk(req, {enc_flag_n, enc_bus_n}, {f, b});
    chk({req, " valid"}, {67'd0, enc_valid_out}, 68'd1);
    enc_valid_in = 0;
  endtask

  task automatic t_reset;  // R11
    rst = 1; enc_valid_in = 1; enc_data_in = '1;
    @(negedge clk); @(negedge clk);
    chk("R11", {enc_flag_n, enc_bus_n}, {68{1'b1}});
    chk("R11 valid", {67'd0, enc_valid_out}, 68'd0);
    rst = 0; enc_valid_in = 0;
  endtask

  task automatic t_plain;  // R1, R2
    encode_check("R1", 64'h0000_0000_0000_0000);
    encode_check("R2", {lane_with(3,0), lane_with(1,5), lane_with(7,2), lane_with(0,0)});
    chk("R1 no-inv lane bits", {4'h0, enc_bus_n}, {4'h0, ~{lane_with(3,0), lane_with(1,5), lane_with(7,2), 16'h0}});
  endtask

  task automatic t_threshold;  // R3, R4, R8
    encode_check("R3", {4{lane_with(9,3)}});
    chk("R3 flags low", {64'd0, enc_flag_n}, 68'd0);
    encode_check("R4", {4{lane_with(8,6)}});
    chk("R4 flags high", {64'd0, enc_flag_n}, 68'hF);
    encode_check("R8", '1);
    chk("R8 all ones sent as highs", {4'h0, enc_bus_n}, {4'h0, 64'hFFFF_FFFF_FFFF_FFFF});
  endtask

  task automatic t_mixed;  // R5
    encode_check("R5", {lane_with(16,0), lane_with(8,1), lane_with(9,4), lane_with(0,0)});
    chk("R5 flags", {64'd0, enc_flag_n}, {64'd0, 4'b0101});
    encode_check("R5", {lane_with(0,0), lane_with(9,11), lane_with(8,0), lane_with(16,0)});
    chk("R5 flags", {64'd0, enc_flag_n}, {64'd0, 4'b1010});
  endtask

  task automatic t_stream;  // R6, R7
    logic [63:0] w[4]; logic [63:0] b; logic [3:0] f;
    w[0] = {4{lane_with(9,0)}}; w[1] = {4{lane_with(8,0)}};
    w[2] = 64'h0123_4567_89AB_CDEF; w[3] = 64'hFFFF_0000_FF00_F0F0;
    @(negedge clk); enc_valid_in = 1; enc_data_in = w[0];
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      expect_enc(w[i-1], b, f);
      chk("R6", {enc_flag_n, enc_bus_n}, {f, b});
      chk("R6 valid", {67'd0, enc_valid_out}, 68'd1);
      if (i < 4) enc_data_in = w[i]; else enc_valid_in = 0;
    end
    enc_data_in = '1;
    @(negedge clk);
    chk("R7", {enc_flag_n, enc_bus_n}, {68{1'b1}});
    chk("R7 valid", {67'd0, enc_valid_out}, 68'd0);
  endtask

  task automatic t_decode;  // R9
    dec_bus_n = 64'h1234_5678_9ABC_DEF0; dec_flag_n = 4'b1010; #1;
    chk("R9", {4'h0, dec_data_out}, {4'h0, ~16'h1234, 16'h5678, ~16'h9ABC, 16'hDEF0});
    dec_flag_n = 4'b1111; #1;
    chk("R9", {4'h0, dec_data_out}, {4'h0, ~64'h1234_5678_9ABC_DEF0});
    dec_flag_n = 4'b0000; #1;
    chk("R9", {4'h0, dec_data_out}, {4'h0, 64'h1234_5678_9ABC_DEF0});
  endtask

  task automatic t_roundtrip;  // R10
    for (int i = 0; i < 40; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      if (i % 4 == 1) d[31:16] = lane_with(8, i);
      if (i % 4 == 2) d[63:48] = lane_with(9, i);
      @(negedge clk); enc_valid_in = 1; enc_data_in = d;
      @(negedge clk);
      dec_bus_n = enc_bus_n; dec_flag_n = enc_flag_n; #1;
      chk("R10", {4'h0, dec_data_out}, {4'h0, d});
    end
    enc_valid_in = 0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    enc_valid_in = 0; enc_data_in = '0; dec_bus_n = '1; dec_flag_n = '1;
    t_reset;
    t_plain;
    t_threshold;
    t_mixed;
    t_stream;
    t_decode;
    t_roundtrip;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule